// File: doc/BRIEF.md
# Sprite Attribute Memory Copy Engine

This block moves a fixed run of bytes, 160 by default, from a 256-byte source page into sprite attribute memory without help from the processor. Software starts a transfer by writing a page number through a one-cycle write strobe. The engine then follows the machine-cycle enable. The first enabled cycle is a setup step that moves nothing. Each of the next 160 enabled cycles moves one byte. One further enabled cycle is the completion step, which returns the engine to idle.

The engine has its own raw decoder for source addresses. The decoder picks the source region (cartridge, video RAM bank 0 or 1, or work RAM) and the address local to that region, and drives them to a generic read port. The data on that port is combinational. In the same cycle the engine writes that byte to the sprite memory write port. A blocking output tells the surrounding bus to hide sprite memory from the processor while copies are under way.

Top module: `sprite_dma_engine`

## Requirements
- R1: After reset, busy and the blocking output are low, the page readback is 0x00, and no sprite write or source read is issued.
- R2: A start write loads the page readback with the written value, raises busy and restarts the sequence at its setup step.
- R3: The first enabled tick after a start write is the setup step. It issues no sprite write and does not change the blocking output.
- R4: Each of the next 160 enabled ticks issues exactly one sprite write. The index counts 0 to 159, and the source address is page×256 + index. A cycle without the tick enable issues no write.
- R5: The blocking output goes high in the cycle after the first copy step and stays high for all remaining copies.
- R6: The enabled tick after the 160th copy is the completion step. It issues no write and clears busy and blocking together, and the engine then stays idle under further ticks.
- R7: A start write that arrives while the blocking output is high keeps blocking high through the new setup step. The new transfer starts again from index 0 with the new page.
- R8: A start write that arrives while blocking is low, including during a setup step, leaves blocking low until the first copy of the new transfer.
- R9: Source addresses from 0xC000 to 0xDFFF select work RAM (region code 3) at address minus 0xC000. Addresses from 0xE000 to 0xFFFF select work RAM at address minus 0xE000.
- R10: Source addresses from 0x8000 to 0x9FFF select video RAM at address minus 0x8000. The region code is 2 (bank 1) when the bank select input is 1, and 1 (bank 0) when it is 0.
- R11: Source addresses from 0x0000 to 0x7FFF and from 0xA000 to 0xBFFF select the cartridge (region code 0) with the full 16-bit address.
- R12: When a start write and a tick enable fall in the same cycle, the start write wins. No copy or step is taken in that cycle.
- R13: The sprite write data equals the source read data in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Machine-cycle enable |
| cfg_wr | input | 1 | Start strobe carrying a page number |
| cfg_page | input | 8 | Source page number written with cfg_wr |
| vram_bank | input | 1 | Video RAM bank select, bit 0 |
| page_q | output | 8 | Readback of the loaded source page |
| busy | output | 1 | Transfer in progress |
| oam_block | output | 1 | Hide sprite memory from the processor |
| src_rd | output | 1 | Source read strobe |
| src_region | output | 2 | Source region code (0 cart, 1 vram0, 2 vram1, 3 wram) |
| src_addr | output | 16 | Address local to the selected region |
| src_rdata | input | 8 | Combinational source read data |
| spr_we | output | 1 | Sprite memory write strobe |
| spr_idx | output | 8 | Sprite memory byte index |
| spr_wdata | output | 8 | Sprite memory write data |

## Verification
A start write can land in the same cycle as a machine-cycle tick. The engine must then take the restart and skip the setup, copy or completion step that the tick would otherwise have caused. The bench provokes this on purpose in three places: in the middle of a copy run, on the setup step, and on the completion step. Random stimulus with a low rate of start writes adds more such cases. The bench judges each case by checking that no write appears in that cycle, that the index starts again at 0 after exactly one later setup tick, and that the blocking output follows the retrigger rule.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  typedef enum logic [1:0] {
    SRC_CART  = 2'd0,
    SRC_VRAM0 = 2'd1,
    SRC_VRAM1 = 2'd2,
    SRC_WRAM  = 2'd3
  } src_region_e;

  // Full source address of one copy step
  function automatic logic [15:0] copy_address(input logic [7:0] page,
                                               input logic [7:0] idx);
    return {page, idx};
  endfunction

  // Region chosen for a raw 16-bit source address
  function automatic src_region_e region_of(input logic [15:0] a,
                                            input logic        bank);
    src_region_e r;
    unique case (a[15:13])
      3'b100:         r = bank ? SRC_VRAM1 : SRC_VRAM0;
      3'b110, 3'b111: r = SRC_WRAM;
      default:        r = SRC_CART;
    endcase
    return r;
  endfunction

  // Address local to the chosen region
  function automatic logic [15:0] local_of(input logic [15:0] a);
    logic [15:0] o;
    unique case (a[15:13])
      3'b100, 3'b110, 3'b111: o = {3'b000, a[12:0]};
      default:                o = a;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/sdma_sequencer.sv
module sdma_sequencer #(
  parameter int XFER_LEN = 160
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       start_wr,
  input  logic [7:0] start_page,
  output logic       busy,
  output logic       block,
  output logic [7:0] page,
  output logic [7:0] cur_idx,
  output logic       setup_step,
  output logic       copy_step,
  output logic       done_step
);
  localparam int POS_W = $clog2(XFER_LEN + 2);
  localparam logic [POS_W-1:0] LAST_COPY = POS_W'(XFER_LEN);
  localparam logic [POS_W-1:0] DONE_POS  = POS_W'(XFER_LEN + 1);

  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] pos_m1;
  logic             advance;

  always_comb begin
    advance    = busy && tick_en && !start_wr;
    setup_step = advance && (pos == '0);
    copy_step  = advance && (pos != '0) && (pos <= LAST_COPY);
    done_step  = advance && (pos == DONE_POS);
    pos_m1     = pos - 1'b1;
    cur_idx    = 8'(pos_m1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      block <= 1'b0;
      page  <= 8'h00;
      pos   <= '0;
    end else if (start_wr) begin
      page  <= start_page;
      busy  <= 1'b1;
      pos   <= '0;
      block <= busy && block;
    end else if (setup_step) begin
      pos <= pos + 1'b1;
    end else if (copy_step) begin
      block <= 1'b1;
      pos   <= pos + 1'b1;
    end else if (done_step) begin
      busy  <= 1'b0;
      block <= 1'b0;
      pos   <= '0;
    end
  end
endmodule

// File: rtl/sdma_src_decode.sv
module sdma_src_decode
  import sdma_pkg::*;
(
  input  logic [15:0] raw_addr,
  input  logic        bank_sel,
  output src_region_e region,
  output logic [15:0] local_addr
);
  always_comb begin
    region     = region_of(raw_addr, bank_sel);
    local_addr = local_of(raw_addr);
  end
endmodule

// File: rtl/sprite_dma_engine.sv
module sprite_dma_engine
  import sdma_pkg::*;
#(
  parameter int XFER_LEN = 160
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_page,
  input  logic        vram_bank,
  output logic [7:0]  page_q,
  output logic        busy,
  output logic        oam_block,
  output logic        src_rd,
  output logic [1:0]  src_region,
  output logic [15:0] src_addr,
  input  logic [7:0]  src_rdata,
  output logic        spr_we,
  output logic [7:0]  spr_idx,
  output logic [7:0]  spr_wdata
);
  logic        setup_step;
  logic        copy_step;
  logic        done_step;
  logic [7:0]  cur_idx;
  logic [15:0] raw_addr;
  src_region_e region;

  sdma_sequencer #(.XFER_LEN(XFER_LEN)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .start_wr   (cfg_wr),
    .start_page (cfg_page),
    .busy       (busy),
    .block      (oam_block),
    .page       (page_q),
    .cur_idx    (cur_idx),
    .setup_step (setup_step),
    .copy_step  (copy_step),
    .done_step  (done_step)
  );

  assign raw_addr = copy_address(page_q, cur_idx);

  sdma_src_decode u_dec (
    .raw_addr   (raw_addr),
    .bank_sel   (vram_bank),
    .region     (region),
    .local_addr (src_addr)
  );

  assign src_region = region;
  assign src_rd     = copy_step;
  assign spr_we     = copy_step;
  assign spr_idx    = cur_idx;
  assign spr_wdata  = src_rdata;
endmodule

// File: rtl/sdma_checks.sv
module sdma_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_en,
  input logic       cfg_wr,
  input logic       busy,
  input logic       oam_block,
  input logic       spr_we,
  input logic [7:0] spr_idx,
  input logic       setup_step,
  input logic       done_step
);
  AST_WE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    spr_we |-> (tick_en && busy && !cfg_wr)); // R4
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    spr_we |=> (!spr_we || spr_idx == $past(spr_idx) + 8'd1)); // R4
  AST_START_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (busy && !spr_we)); // R2
  AST_SETUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    setup_step |-> !spr_we); // R3
  AST_COPY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    spr_we |=> oam_block); // R5
  AST_BLOCK_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    oam_block |-> busy); // R5
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    done_step |=> (!busy && !oam_block)); // R6
  AST_RETRIG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && oam_block) |=> oam_block); // R7
  AST_RETRIG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !oam_block) |=> !oam_block); // R8
  AST_START_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> (!spr_we && !done_step && !setup_step)); // R12
endmodule

bind sprite_dma_engine sdma_checks u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .cfg_wr     (cfg_wr),
  .busy       (busy),
  .oam_block  (oam_block),
  .spr_we     (spr_we),
  .spr_idx    (spr_idx),
  .setup_step (setup_step),
  .done_step  (done_step)
);

// File: tb/sprite_dma_engine_test.sv
module sprite_dma_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_page = 8'h00;
  logic        vram_bank = 1'b0;
  logic [7:0]  page_q;
  logic        busy, oam_block, src_rd, spr_we;
  logic [1:0]  src_region;
  logic [15:0] src_addr;
  logic [7:0]  src_rdata, spr_idx, spr_wdata;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench reference model
  bit       m_busy = 0;
  bit       m_blk = 0;
  int       m_pos = 0;
  bit [7:0] m_page = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] mem_data(input logic [1:0] r, input logic [15:0] a);
    return a[7:0] ^ (a[15:8] + 8'h3B) ^ {r, 6'b0};
  endfunction

  assign src_rdata = mem_data(src_region, src_addr);

  sprite_dma_engine uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_wr(cfg_wr),
    .cfg_page(cfg_page), .vram_bank(vram_bank), .page_q(page_q),
    .busy(busy), .oam_block(oam_block), .src_rd(src_rd),
    .src_region(src_region), .src_addr(src_addr), .src_rdata(src_rdata),
    .spr_we(spr_we), .spr_idx(spr_idx), .spr_wdata(spr_wdata)
  );

  function automatic logic [1:0] exp_region(input int a, input bit bank);
    if (a < 'h8000) return 2'd0;
    if (a < 'hA000) return bank ? 2'd2 : 2'd1;
    if (a < 'hC000) return 2'd0;
    return 2'd3;
  endfunction

  function automatic logic [15:0] exp_local(input int a);
    if (a < 'h8000) return 16'(a);
    if (a < 'hA000) return 16'(a - 'h8000);
    if (a < 'hC000) return 16'(a);
    if (a < 'hE000) return 16'(a - 'hC000);
    return 16'(a - 'hE000);
  endfunction

  function automatic string dec_tag(input int a);
    if (a >= 'h8000 && a < 'hA000) return "R10";
    if (a >= 'hC000) return "R9";
    return "R11";
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit wr, input logic [7:0] pg, input bit tk);
    bit exp_we;
    int a;
    @(negedge clk);
    cfg_wr = wr; cfg_page = pg; tick_en = tk;
    #1;
    exp_we = m_busy && tk && !wr && m_pos >= 1 && m_pos <= 160;
    if (wr && tk && m_busy) check("R12 write wins", spr_we, 0);
    else if (m_busy && tk && m_pos == 0) check("R3 setup no write", spr_we, 0);
    else if (m_busy && tk && m_pos == 161) check("R6 done no write", spr_we, 0);
    else check("R4 write strobe", spr_we, exp_we);
    if (exp_we && spr_we) begin
      a = {m_page, 8'(m_pos - 1)};
      check("R4 index", spr_idx, m_pos - 1);
      check(dec_tag(a), src_region, exp_region(a, vram_bank));
      check(dec_tag(a), src_addr, exp_local(a));
      check("R13 data", spr_wdata, mem_data(exp_region(a, vram_bank), exp_local(a)));
    end
    @(posedge clk);
    if (wr) begin
      m_blk = m_busy && m_blk; m_busy = 1; m_pos = 0; m_page = pg;
    end else if (tk && m_busy) begin
      if (m_pos == 0) m_pos = 1;
      else if (m_pos <= 160) begin m_blk = 1; m_pos++; end
      else begin m_busy = 0; m_blk = 0; m_pos = 0; end
    end
    #1;
    check("R6 busy", busy, m_busy);
    check("R5 block", oam_block, m_blk);
    check("R2 page", page_q, m_page);
    cfg_wr = 0; tick_en = 0;
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 1);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit [31:0] seed;
    seed = $urandom(32'h5D1A);
    repeat (3) @(posedge clk);
    #1;
    check("R1 busy", busy, 0);
    check("R1 block", oam_block, 0);
    check("R1 page", page_q, 0);
    check("R1 no write", spr_we, 0);
    check("R1 no read", src_rd, 0);
    @(negedge clk); rst_n = 1;

    // full transfer from work RAM, continuous ticks, then idle ticks
    step(1, 8'hC1, 0);
    check("R2 page load", page_q, 8'hC1);
    run_ticks(170);
    check("R6 idle", busy, 0);

    // video RAM both banks with gaps
    vram_bank = 0;
    step(1, 8'h85, 0);
    for (int i = 0; i < 250; i++) step(0, 8'h00, (i % 3) != 0);
    vram_bank = 1;
    step(1, 8'h9F, 0);
    run_ticks(165);

    // echo, cartridge pages
    step(1, 8'hE3, 0); run_ticks(165);
    step(1, 8'hFE, 0); run_ticks(165);
    step(1, 8'h12, 0); run_ticks(165);
    step(1, 8'hA7, 0); run_ticks(165);

    // retrigger mid-copy keeps blocking
    step(1, 8'hC4, 1);
    run_ticks(30);
    step(1, 8'h90, 0);
    check("R7 block kept", oam_block, 1);
    step(0, 8'h00, 1);
    check("R7 block through setup", oam_block, 1);
    step(0, 8'h00, 1);
    run_ticks(165);

    // retrigger during setup leaves blocking low
    step(1, 8'hD0, 0);
    step(1, 8'hD2, 0);
    check("R8 low after retrigger", oam_block, 0);
    step(0, 8'h00, 1);
    step(1, 8'hD3, 0);
    check("R8 low after setup retrigger", oam_block, 0);
    step(0, 8'h00, 1);
    check("R8 low through setup", oam_block, 0);
    run_ticks(165);

    // start write coinciding with tick at copy, setup and completion
    step(1, 8'hC8, 0);
    run_ticks(50);
    step(1, 8'hCA, 1);
    step(1, 8'hCB, 1);
    run_ticks(161);
    step(1, 8'hCC, 1);
    check("R12 restart busy", busy, 1);
    run_ticks(165);

    // constrained random mix
    for (int i = 0; i < 6000; i++) begin
      vram_bank = ($urandom % 4) == 0;
      step(($urandom % 220) == 0, 8'($urandom), ($urandom % 4) != 0);
    end
    run_ticks(170);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule